// File: doc/BRIEF.md
# Two-Wire Serial Clock Divider

This block derives the serial clock of a two-wire bus master from the system clock. Three programmable settings shape the timing: an 8-bit half-period count (HPC), a 4-bit multiplier divisor M and a 3-bit power-of-two exponent N. The divider is a chain of three counters. The first counter wraps every HPC+1 system cycles. The second counts 2^N of those wraps. The third counts (M+1)·10 wraps of the second. Each wrap of the last stage ends one half period of SCL. The block then toggles its SCL output and raises a one-cycle tick for the master engine.

Software loads the half-period count through one write strobe. It loads M and N through a second strobe as one packed control word. Writes land in shadow registers. The working settings copy the shadows only at a half-period boundary, so a setting never changes in the middle of an SCL phase. When SCL is released high but the sensed line is still low, a slave is stretching the clock and the whole chain holds.

The block carries no data stream, so no valid/ready handshake applies. Every pin is a plain control or status signal: write strobes with data, the sensed line, the driven line and the tick.

Top module: `scl_divgen`

## Requirements
- R1: After reset, scl_out is high (released) and tick is low. The working settings are HPC = 0x18, M = 2 and N = 0, so the first half period lasts 750 system cycles.
- R2: One SCL half period lasts (max(HPC,5)+1)·2^N·(M+1)·10 system cycles, giving f_scl = f_sys / (2·(HPC+1)) / 2^N / (M+1) / 10. scl_out inverts at the end of every half period.
- R3: In the control word, bits 6:3 carry M and bits 2:0 carry N. The word is written when cc_we is high.
- R4: An HPC value below 5 behaves exactly as 5.
- R5: A setting written during a half period does not change that half period. It governs every half period that starts after the next boundary.
- R6: While scl_out is high and scl_in is low, the divider does not advance, so a high phase lasts one cycle longer for each stretched cycle. A low scl_in during a low phase has no effect.
- R7: tick is high for exactly one cycle, in the same cycle that scl_out takes its new level.
- R8: A write of HPC leaves M and N unchanged, and a write of the control word leaves HPC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thp_we | input | 1 | Write strobe for the half-period count |
| thp_wdata | input | 8 | Half-period count to write |
| cc_we | input | 1 | Write strobe for the control word |
| cc_wdata | input | 7 | Control word: M in bits 6:3, N in bits 2:0 |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_out | output | 1 | SCL drive level: 1 releases the line, 0 pulls it low |
| tick | output | 1 | One-cycle pulse at each half-period boundary |

## Verification
Half-period lengths are measured under several kinds of setting:
- the reset settings;
- a clamped HPC;
- nonzero N and M values, which separate the exponent stage from the multiplier stage;
- random mixes of all three fields.

Writes that land in the middle of a half period show whether a setting takes effect early or at the boundary. Writes of a single field show whether the two registers keep their contents apart. Stretch pulses are placed in both high and low phases. A correct divider lengthens only the high phase, which separates a correct hold from one that ignores the drive level or never holds.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned THP_W   = 8;
  localparam int unsigned M_W     = 4;
  localparam int unsigned N_W     = 3;
  localparam int unsigned CC_W    = M_W + N_W;
  localparam int unsigned FIX_DIV = 10;
  localparam int unsigned THP_MIN = 5;
  localparam int unsigned THP_RST = 8'h18;
  localparam int unsigned M_RST   = 2;
  localparam int unsigned N_RST   = 0;
  // widest count each downstream stage must reach
  localparam int unsigned N_CNT_W = (1 << N_W) - 1;
  localparam int unsigned M_CNT_W = $clog2((1 << M_W) * FIX_DIV);

  typedef struct packed {
    logic [THP_W-1:0] thp;
    logic [M_W-1:0]   m;
    logic [N_W-1:0]   n;
  } div_cfg_t;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thp_we,
  input  logic [THP_W-1:0] thp_wdata,
  input  logic             cc_we,
  input  logic [CC_W-1:0]  cc_wdata,
  input  logic             commit,
  output div_cfg_t         act
);
  div_cfg_t         shadow;
  logic [THP_W-1:0] thp_clamped;

  assign thp_clamped = (thp_wdata < THP_W'(THP_MIN)) ? THP_W'(THP_MIN) : thp_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow.thp <= THP_W'(THP_RST);
      shadow.m   <= M_W'(M_RST);
      shadow.n   <= N_W'(N_RST);
    end else begin
      if (thp_we) shadow.thp <= thp_clamped;
      if (cc_we) begin
        shadow.m <= cc_wdata[CC_W-1:N_W];
        shadow.n <= cc_wdata[N_W-1:0];
      end
    end
  end

  // working copy only moves at a half-period boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act.thp <= THP_W'(THP_RST);
      act.m   <= M_W'(M_RST);
      act.n   <= N_W'(N_RST);
    end else if (commit) begin
      act <= shadow;
    end
  end

  // R4: the working half-period count never drops below the floor
  a_r4_thp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act.thp >= THP_W'(THP_MIN));

  // R5: working settings move only in the cycle after a boundary
  a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act));
endmodule

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         wrap,
  output logic [W-1:0] cnt
);
  assign wrap = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (en)   cnt <= cnt + W'(1);
  end

  // R2: a stage never counts past its own limit
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
endmodule

// File: rtl/scl_div_out.sv
module scl_div_out (
  input  logic clk,
  input  logic rst_n,
  input  logic terminal,
  output logic scl_q,
  output logic tick_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      tick_q <= terminal;
      if (terminal) scl_q <= ~scl_q;
    end
  end

  // R7: tick lasts one cycle
  a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R7: SCL only changes level together with a tick
  a_r7_scl_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q != $past(scl_q)) |-> tick_q);
endmodule

// File: rtl/scl_divgen.sv
module scl_divgen
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thp_we,
  input  logic [THP_W-1:0] thp_wdata,
  input  logic             cc_we,
  input  logic [CC_W-1:0]  cc_wdata,
  input  logic             scl_in,
  output logic             scl_out,
  output logic             tick
);
  div_cfg_t             act;
  logic                 hold, adv;
  logic                 wrap_hp, wrap_n, wrap_m;
  logic [THP_W-1:0]     cnt_hp;
  logic [N_CNT_W-1:0]   cnt_n, lim_n;
  logic [M_CNT_W-1:0]   cnt_m, lim_m;

  // stretching: released high but the line still reads low
  assign hold  = scl_out & ~scl_in;
  assign adv   = ~hold;
  assign lim_n = N_CNT_W'((1 << act.n) - 1);
  assign lim_m = M_CNT_W'((int'(act.m) + 1) * FIX_DIV - 1);

  scl_div_cfg u_cfg (
    .clk, .rst_n, .thp_we, .thp_wdata, .cc_we, .cc_wdata,
    .commit (wrap_m),
    .act    (act)
  );

  scl_div_stage #(.W(THP_W)) u_hp (
    .clk, .rst_n, .en(adv), .lim(act.thp), .wrap(wrap_hp), .cnt(cnt_hp)
  );

  scl_div_stage #(.W(N_CNT_W)) u_pow (
    .clk, .rst_n, .en(wrap_hp), .lim(lim_n), .wrap(wrap_n), .cnt(cnt_n)
  );

  scl_div_stage #(.W(M_CNT_W)) u_mul (
    .clk, .rst_n, .en(wrap_n), .lim(lim_m), .wrap(wrap_m), .cnt(cnt_m)
  );

  scl_div_out u_out (
    .clk, .rst_n, .terminal(wrap_m), .scl_q(scl_out), .tick_q(tick)
  );

  // R6: a stretched cycle freezes the first stage and produces no tick
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_hp) && !tick);

  // R6: a held cycle leaves the upper stages untouched
  a_r6_hold_upper: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_n) && $stable(cnt_m));
endmodule

// File: tb/scl_divgen_tb.sv
module scl_divgen_tb;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       thp_we, cc_we, stretch;
  logic [7:0] thp_wdata;
  logic [6:0] cc_wdata;
  logic       scl_in, scl_out, tick;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic exp_scl;
  int act_thp, act_m, act_n, sh_thp, sh_m, sh_n;

  always #(CLK_P/2) clk = ~clk;
  assign scl_in = scl_out & ~stretch;

  scl_divgen u_dut (
    .clk, .rst_n, .thp_we, .thp_wdata, .cc_we, .cc_wdata,
    .scl_in, .scl_out, .tick
  );

  function automatic int half_len(int t, int m, int n);
    int tt = (t < 5) ? 5 : t;
    return (tt + 1) * (1 << n) * (m + 1) * 10;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One half period: optional mid-period writes, optional stretch at its start.
  task automatic run_half(string req, int wr_at, bit wt, int tv, bit wc,
                          int ccv, int st);
    int cyc = 0;
    int exp = half_len(act_thp, act_m, act_n) + (exp_scl ? st : 0);
    stretch = (st > 0);
    while (1) begin
      @(negedge clk);
      cyc++;
      thp_we = 1'b0;
      cc_we  = 1'b0;
      if (cyc == 1) check(tick == 1'b0, "R7", int'(tick), 0);
      if (cyc == wr_at) begin
        thp_we = wt; thp_wdata = 8'(tv);
        cc_we  = wc; cc_wdata  = 7'(ccv);
      end
      stretch = (cyc < st);
      if (tick || cyc > 60000) break;
    end
    thp_we = 1'b0; cc_we = 1'b0; stretch = 1'b0;
    check(cyc == exp, req, cyc, exp);
    exp_scl = ~exp_scl;
    check(scl_out == exp_scl, "R2", int'(scl_out), int'(exp_scl));
    if (wt) sh_thp = tv;
    if (wc) begin sh_m = (ccv >> 3) & 15; sh_n = ccv & 7; end
    act_thp = sh_thp; act_m = sh_m; act_n = sh_n;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    rst_n = 1'b0; thp_we = 0; cc_we = 0; stretch = 0;
    thp_wdata = '0; cc_wdata = '0;
    act_thp = 8'h18; act_m = 2; act_n = 0;
    sh_thp = act_thp; sh_m = act_m; sh_n = act_n;
    exp_scl = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_out == 1'b1, "R1", int'(scl_out), 1);
    check(tick == 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
    // R1: reset settings give a 750-cycle half period
    run_half("R1", 0, 0, 0, 0, 0, 0);
    // R5: clamped setting written mid-period; old length still applies
    run_half("R5", 5, 1, 0, 1, 0, 0);
    // R4: HPC 0 behaves as 5 -> 60 cycles
    run_half("R4", 0, 0, 0, 0, 0, 0);
    // R3: M=1 (bits 6:3), N=1 (bits 2:0)
    run_half("R5", 3, 1, 5, 1, (1 << 3) | 1, 0);
    run_half("R3", 0, 0, 0, 0, 0, 0);
    // R8: single-field writes leave the other register alone
    run_half("R8", 7, 1, 9, 0, 0, 0);
    run_half("R8", 7, 0, 0, 1, (2 << 3) | 0, 0);
    run_half("R8", 0, 0, 0, 0, 0, 0);
    // R6: stretch in two consecutive phases (one high, one low)
    run_half("R6", 0, 0, 0, 0, 0, 25);
    run_half("R6", 0, 0, 0, 0, 0, 25);
    // R2: random settings, writes and stretches
    for (int i = 0; i < 10; i++) begin
      int t  = $urandom_range(0, 20);
      int m  = $urandom_range(0, 3);
      int n  = $urandom_range(0, 2);
      int wa = $urandom_range(2, 40);
      int st = $urandom_range(0, 30);
      run_half("R5", wa, 1, t, 1, (m << 3) | n, st);
      run_half("R2", 0, 0, 0, 0, 0, $urandom_range(0, 30));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule